// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flags

This block takes two IEEE-754 binary operands and reports their relation as a 4-bit condition flag set (N, Z, C, V). The relation is one of four outcomes: less, equal, greater or unordered. A single input selects between single precision, held in the low 32 bits of each operand bus, and double precision, which uses the full 64 bits. Denormal operands are compared exactly as stored; they are never flushed to zero.

A second select picks the exception policy. In quiet mode, the invalid-operation output is raised only when an operand is a signalling NaN. In signalling mode, any NaN operand raises it. The result is registered: a compare accepted on one clock edge appears on the outputs after that edge, and the outputs hold their value until the next accepted compare.

Top module: `fcmp_flags`

## Requirements
- R1: When the operands are equal, `flags` = 4'b0110 (flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V), so Z=1 and C=1.
- R2: When A is less than B, `flags` = 4'b1000 (N only).
- R3: When A is greater than B, `flags` = 4'b0010 (C only).
- R4: When either operand is a NaN (exponent all ones, mantissa nonzero), the result is unordered and `flags` = 4'b0011 (C and V).
- R5: +0 and -0 compare as equal in either order.
- R6: Ordering is decided first by sign, then by exponent, then by mantissa. The order is reversed when both operands are negative. Infinities and denormals follow the same rule.
- R7: With `is_double`=0, only bits [31:0] of each operand are used and bits [63:32] have no effect. With `is_double`=1, all 64 bits form a double.
- R8: With `signal_mode`=0, `invalid` is 1 only if an operand is a signalling NaN, meaning a NaN whose top mantissa bit is 0. A quiet NaN (top mantissa bit 1) gives `invalid`=0.
- R9: With `signal_mode`=1, `invalid` is 1 for any NaN operand and 0 otherwise.
- R10: `out_valid` equals `in_valid` one cycle later. `flags` and `invalid` change only on a cycle where `in_valid` is 1, and hold their value otherwise.
- R11: While `rst_n` is 0 at a clock edge, `out_valid`, `flags` and `invalid` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept a compare this cycle |
| is_double | input | 1 | 1 = double precision, 0 = single precision in bits [31:0] |
| signal_mode | input | 1 | 1 = any NaN raises invalid, 0 = only signalling NaN does |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| out_valid | output | 1 | Result registered this cycle |
| flags | output | 4 | {N, Z, C, V} |
| invalid | output | 1 | Invalid-operation indication for the last compare |

## Verification
The assertions assume that `in_valid`, `is_double`, `signal_mode` and both operands are known (not X) whenever `rst_n` is 1. They also assume that reset is held for at least one clock edge before the first compare. The bench respects both assumptions. It holds reset with all inputs at zero, and it changes inputs only on the falling edge, so every rising edge samples settled values. The bench also lowers `in_valid` between scenarios, so that the latency and hold properties are exercised on idle cycles as well as on compares.

// File: rtl/fcmp_pkg.sv
// Package: shared relation type and flag encodings for the compare block.
// Assumes flags are packed {N, Z, C, V} from bit 3 down to bit 0.
package fcmp_pkg;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    localparam logic [3:0] FLAGS_LT = 4'b1000;
    localparam logic [3:0] FLAGS_EQ = 4'b0110;
    localparam logic [3:0] FLAGS_GT = 4'b0010;
    localparam logic [3:0] FLAGS_UN = 4'b0011;

    // Map a relation onto its fixed condition-flag pattern.
    function automatic logic [3:0] rel_to_flags(input rel_e rel);
        logic [3:0] f;
        case (rel)
            REL_LT:  f = FLAGS_LT;
            REL_EQ:  f = FLAGS_EQ;
            REL_GT:  f = FLAGS_GT;
            default: f = FLAGS_UN;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fcmp_unpack.sv
// Module: fcmp_unpack
// Splits one IEEE-754 word of a given format into its sign, an unsigned
// magnitude key (exponent above mantissa, zero-extended to MAG_W) and the
// class bits needed by the compare: zero, NaN and signalling NaN.
// Assumes MAG_W >= EXP_W + MAN_W and MAN_W >= 1.
module fcmp_unpack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int MAG_W = 63
) (
    input  logic [EXP_W+MAN_W:0] word,
    output logic                 sign,
    output logic [MAG_W-1:0]     mag,
    output logic                 is_zero,
    output logic                 is_nan,
    output logic                 is_snan
);
    localparam int BODY_W = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    // Field extraction and class decode for one operand.
    always_comb begin
        sign    = word[BODY_W];
        exp_f   = word[BODY_W-1:MAN_W];
        man_f   = word[MAN_W-1:0];
        mag     = MAG_W'(word[BODY_W-1:0]);
        is_zero = (exp_f == '0) && (man_f == '0);
        is_nan  = (exp_f == '1) && (man_f != '0);
        is_snan = is_nan && !man_f[MAN_W-1];
    end

endmodule

// File: rtl/fcmp_order.sv
// Module: fcmp_order
// Decides the relation of two unpacked operands: unordered if either is a
// NaN, equal for any pair of zeros, otherwise by sign then magnitude key,
// with the magnitude order reversed when both operands are negative.
// Assumes magnitude keys order like the values they encode (IEEE layout).
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  logic             sign_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             zero_a,
    input  logic             nan_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             zero_b,
    input  logic             nan_b,
    output rel_e             rel
);
    logic mag_lt;
    logic mag_eq;

    // Relation decision, with special classes taking precedence.
    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_eq = (mag_a == mag_b);
        if (nan_a || nan_b) begin
            rel = REL_UN;
        end else if (zero_a && zero_b) begin
            rel = REL_EQ;
        end else if (sign_a != sign_b) begin
            rel = sign_a ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel = REL_EQ;
        end else if (sign_a) begin
            rel = mag_lt ? REL_GT : REL_LT;
        end else begin
            rel = mag_lt ? REL_LT : REL_GT;
        end
    end

endmodule

// File: rtl/fcmp_policy.sv
// Module: fcmp_policy
// Applies the NaN exception policy: in quiet mode only a signalling NaN
// raises invalid; in signalling mode any NaN does.
// Assumes the class inputs come from fcmp_unpack for the selected format.
module fcmp_policy (
    input  logic nan_a,
    input  logic snan_a,
    input  logic nan_b,
    input  logic snan_b,
    input  logic signal_mode,
    output logic raise_invalid
);
    // Invalid decision per mode.
    always_comb begin
        if (signal_mode) begin
            raise_invalid = nan_a || nan_b;
        end else begin
            raise_invalid = snan_a || snan_b;
        end
    end

endmodule

// File: rtl/fcmp_flags.sv
// Module: fcmp_flags (top)
// Compares two IEEE-754 operands in single or double precision and
// registers the {N,Z,C,V} flag pattern and an invalid indication one cycle
// after an accepted compare. Outputs hold between compares.
// Assumes single-precision operands sit in the low SP_W bits of each bus;
// inputs are known whenever rst_n is high. Reset is synchronous, active low.
module fcmp_flags
    import fcmp_pkg::*;
#(
    parameter int SP_EXP_W = 8,
    parameter int SP_MAN_W = 23,
    parameter int DP_EXP_W = 11,
    parameter int DP_MAN_W = 52
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          is_double,
    input  logic                          signal_mode,
    input  logic [DP_EXP_W+DP_MAN_W:0]    op_a,
    input  logic [DP_EXP_W+DP_MAN_W:0]    op_b,
    output logic                          out_valid,
    output logic [3:0]                    flags,
    output logic                          invalid
);
    localparam int SP_W  = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W  = 1 + DP_EXP_W + DP_MAN_W;
    localparam int MAG_W = DP_EXP_W + DP_MAN_W;
    localparam int NOPS  = 2;

    logic [DP_W-1:0]  ops    [NOPS];
    logic             sign_v [NOPS];
    logic [MAG_W-1:0] mag_v  [NOPS];
    logic             zero_v [NOPS];
    logic             nan_v  [NOPS];
    logic             snan_v [NOPS];

    rel_e rel;
    logic raise_invalid;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One pair of unpackers per operand, muxed by the precision select.
    for (genvar g = 0; g < NOPS; g++) begin : g_operand
        logic             s_sign, d_sign;
        logic [MAG_W-1:0] s_mag,  d_mag;
        logic             s_zero, d_zero;
        logic             s_nan,  d_nan;
        logic             s_snan, d_snan;

        fcmp_unpack #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .MAG_W(MAG_W)) u_sp (
            .word    (ops[g][SP_W-1:0]),
            .sign    (s_sign),
            .mag     (s_mag),
            .is_zero (s_zero),
            .is_nan  (s_nan),
            .is_snan (s_snan)
        );

        fcmp_unpack #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W), .MAG_W(MAG_W)) u_dp (
            .word    (ops[g]),
            .sign    (d_sign),
            .mag     (d_mag),
            .is_zero (d_zero),
            .is_nan  (d_nan),
            .is_snan (d_snan)
        );

        // Precision select for this operand's unpacked view.
        always_comb begin
            sign_v[g] = is_double ? d_sign : s_sign;
            mag_v[g]  = is_double ? d_mag  : s_mag;
            zero_v[g] = is_double ? d_zero : s_zero;
            nan_v[g]  = is_double ? d_nan  : s_nan;
            snan_v[g] = is_double ? d_snan : s_snan;
        end
    end

    fcmp_order #(.MAG_W(MAG_W)) u_order (
        .sign_a (sign_v[0]),
        .mag_a  (mag_v[0]),
        .zero_a (zero_v[0]),
        .nan_a  (nan_v[0]),
        .sign_b (sign_v[1]),
        .mag_b  (mag_v[1]),
        .zero_b (zero_v[1]),
        .nan_b  (nan_v[1]),
        .rel    (rel)
    );

    fcmp_policy u_policy (
        .nan_a         (nan_v[0]),
        .snan_a        (snan_v[0]),
        .nan_b         (nan_v[1]),
        .snan_b        (snan_v[1]),
        .signal_mode   (signal_mode),
        .raise_invalid (raise_invalid)
    );

    // Result register: capture on accepted compare, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            flags     <= 4'b0000;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                flags   <= rel_to_flags(rel);
                invalid <= raise_invalid;
            end
        end
    end

    // R1 R2 R3 R4: a valid result is always one of the four fixed patterns.
    assert_legal_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags == FLAGS_LT || flags == FLAGS_EQ ||
                       flags == FLAGS_GT || flags == FLAGS_UN));

    // R5: any pair of zeros yields the equal pattern.
    assert_zero_pair_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_v[0] && zero_v[1]) |=> (flags == FLAGS_EQ));

    // R6 R2: a negative non-NaN A against a positive B, not both zero, is less.
    assert_sign_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !nan_v[0] && !nan_v[1] && sign_v[0] && !sign_v[1] &&
         !(zero_v[0] && zero_v[1])) |=> (flags == FLAGS_LT));

    // R8: in quiet mode invalid can only accompany an unordered result.
    assert_quiet_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !signal_mode) |=> (!invalid || flags == FLAGS_UN));

    // R9: in signalling mode invalid is set exactly when unordered.
    assert_signal_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && signal_mode) |=> (invalid == (flags == FLAGS_UN)));

    // R10: valid follows the request by one cycle.
    assert_latency_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_latency_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: results hold on idle cycles.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(flags) && $stable(invalid)));

endmodule

// File: tb/fcmp_flags_test.sv
// Directed bench for fcmp_flags: one task per scenario, each checking its
// own results. Inputs change on the falling edge; outputs are sampled on
// the falling edge after the capturing rising edge.
module fcmp_flags_test;
    localparam logic [3:0] F_LT = 4'b1000;
    localparam logic [3:0] F_EQ = 4'b0110;
    localparam logic [3:0] F_GT = 4'b0010;
    localparam logic [3:0] F_UN = 4'b0011;

    // Single-precision constants (low 32 bits).
    localparam logic [31:0] S_PZERO = 32'h0000_0000;
    localparam logic [31:0] S_NZERO = 32'h8000_0000;
    localparam logic [31:0] S_ONE   = 32'h3F80_0000;
    localparam logic [31:0] S_TWO   = 32'h4000_0000;
    localparam logic [31:0] S_MONE  = 32'hBF80_0000;
    localparam logic [31:0] S_MTWO  = 32'hC000_0000;
    localparam logic [31:0] S_PINF  = 32'h7F80_0000;
    localparam logic [31:0] S_NINF  = 32'hFF80_0000;
    localparam logic [31:0] S_QNAN  = 32'h7FC0_0000;
    localparam logic [31:0] S_SNAN  = 32'h7F80_0001;
    localparam logic [31:0] S_DEN1  = 32'h0000_0001;
    localparam logic [31:0] S_DEN2  = 32'h0000_0002;
    localparam logic [31:0] S_MDEN1 = 32'h8000_0001;

    // Double-precision constants.
    localparam logic [63:0] D_ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_MONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_DEN1  = 64'h0000_0000_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_double = 1'b0;
    logic        signal_mode = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [3:0]  flags;
    logic        invalid;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    fcmp_flags uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .is_double   (is_double),
        .signal_mode (signal_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .out_valid   (out_valid),
        .flags       (flags),
        .invalid     (invalid)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one compare, then check valid, flags and invalid one cycle later.
    task automatic run_cmp(input string req, input logic dbl, input logic sig,
                           input logic [63:0] a, input logic [63:0] b,
                           input logic [3:0] exp_f, input logic exp_inv);
        @(negedge clk);
        is_double   = dbl;
        signal_mode = sig;
        op_a        = a;
        op_b        = b;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid    = 1'b0;
        check(req, "out_valid", {63'b0, out_valid}, 64'd1);
        check(req, "flags", {60'b0, flags}, {60'b0, exp_f});
        check(req, "invalid", {63'b0, invalid}, {63'b0, exp_inv});
    endtask

    task automatic t_reset();
        // R11: reset state.
        check("R11", "out_valid", {63'b0, out_valid}, 64'd0);
        check("R11", "flags", {60'b0, flags}, 64'd0);
        check("R11", "invalid", {63'b0, invalid}, 64'd0);
    endtask

    task automatic t_equal();
        run_cmp("R1", 1'b0, 1'b0, {32'h0, S_ONE}, {32'h0, S_ONE}, F_EQ, 1'b0);
        run_cmp("R1", 1'b1, 1'b1, D_TWO, D_TWO, F_EQ, 1'b0);
        run_cmp("R1", 1'b0, 1'b0, {32'h0, S_NINF}, {32'h0, S_NINF}, F_EQ, 1'b0);
    endtask

    task automatic t_order_positive();
        run_cmp("R2", 1'b0, 1'b0, {32'h0, S_ONE}, {32'h0, S_TWO}, F_LT, 1'b0);
        run_cmp("R3", 1'b0, 1'b0, {32'h0, S_TWO}, {32'h0, S_ONE}, F_GT, 1'b0);
        run_cmp("R2", 1'b1, 1'b0, D_ONE, D_TWO, F_LT, 1'b0);
        run_cmp("R3", 1'b1, 1'b0, D_PINF, D_TWO, F_GT, 1'b0);
    endtask

    task automatic t_order_negative();
        // R6: both negative reverses magnitude order; mixed signs by sign.
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_MTWO}, {32'h0, S_MONE}, F_LT, 1'b0);
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_MONE}, {32'h0, S_MTWO}, F_GT, 1'b0);
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_MONE}, {32'h0, S_ONE}, F_LT, 1'b0);
        run_cmp("R6", 1'b1, 1'b0, D_ONE, D_MONE, F_GT, 1'b0);
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_NINF}, {32'h0, S_MTWO}, F_LT, 1'b0);
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_PINF}, {32'h0, S_NINF}, F_GT, 1'b0);
    endtask

    task automatic t_zeros();
        run_cmp("R5", 1'b0, 1'b0, {32'h0, S_PZERO}, {32'h0, S_NZERO}, F_EQ, 1'b0);
        run_cmp("R5", 1'b0, 1'b1, {32'h0, S_NZERO}, {32'h0, S_PZERO}, F_EQ, 1'b0);
        run_cmp("R5", 1'b1, 1'b0, D_NZERO, 64'h0, F_EQ, 1'b0);
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_NZERO}, {32'h0, S_DEN1}, F_LT, 1'b0);
    endtask

    task automatic t_denormals();
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_DEN1}, {32'h0, S_DEN2}, F_LT, 1'b0);
        run_cmp("R6", 1'b0, 1'b0, {32'h0, S_MDEN1}, {32'h0, S_PZERO}, F_LT, 1'b0);
        run_cmp("R6", 1'b1, 1'b0, D_DEN1, 64'h0, F_GT, 1'b0);
    endtask

    task automatic t_nan_quiet();
        run_cmp("R8", 1'b0, 1'b0, {32'h0, S_QNAN}, {32'h0, S_ONE}, F_UN, 1'b0);
        run_cmp("R8", 1'b0, 1'b0, {32'h0, S_ONE}, {32'h0, S_SNAN}, F_UN, 1'b1);
        run_cmp("R8", 1'b1, 1'b0, D_QNAN, D_QNAN, F_UN, 1'b0);
        run_cmp("R8", 1'b1, 1'b0, D_SNAN, D_ONE, F_UN, 1'b1);
    endtask

    task automatic t_nan_signal();
        run_cmp("R9", 1'b0, 1'b1, {32'h0, S_QNAN}, {32'h0, S_ONE}, F_UN, 1'b1);
        run_cmp("R9", 1'b1, 1'b1, D_ONE, D_QNAN, F_UN, 1'b1);
        run_cmp("R9", 1'b0, 1'b1, {32'h0, S_SNAN}, {32'h0, S_QNAN}, F_UN, 1'b1);
        run_cmp("R4", 1'b0, 1'b1, {32'h0, S_PINF}, {32'h0, S_QNAN}, F_UN, 1'b1);
        run_cmp("R9", 1'b0, 1'b1, {32'h0, S_TWO}, {32'h0, S_ONE}, F_GT, 1'b0);
    endtask

    task automatic t_precision_select();
        // R7: upper bits ignored in single mode.
        run_cmp("R7", 1'b0, 1'b0, {32'hFFFF_FFFF, S_ONE}, {32'h0, S_TWO}, F_LT, 1'b0);
        run_cmp("R7", 1'b0, 1'b1, {32'h7FF8_0000, S_ONE}, {32'h1234_5678, S_ONE}, F_EQ, 1'b0);
        // R7: same bits as doubles are compared on all 64 bits.
        run_cmp("R7", 1'b1, 1'b0, {32'h3FF0_0000, S_TWO}, {32'h3FF0_0000, S_ONE}, F_GT, 1'b0);
    endtask

    task automatic t_hold();
        // R10: idle cycles with changed inputs leave results untouched.
        run_cmp("R10", 1'b0, 1'b1, {32'h0, S_QNAN}, {32'h0, S_ONE}, F_UN, 1'b1);
        op_a = {32'h0, S_ONE};
        op_b = {32'h0, S_TWO};
        signal_mode = 1'b0;
        @(negedge clk);
        check("R10", "out_valid idle", {63'b0, out_valid}, 64'd0);
        check("R10", "flags held", {60'b0, flags}, {60'b0, F_UN});
        check("R10", "invalid held", {63'b0, invalid}, 64'd1);
        @(negedge clk);
        check("R10", "flags held 2", {60'b0, flags}, {60'b0, F_UN});
    endtask

    task automatic t_reset_again();
        // R11: reset mid-run clears outputs.
        run_cmp("R11", 1'b0, 1'b0, {32'h0, S_ONE}, {32'h0, S_SNAN}, F_UN, 1'b1);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        t_reset();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_equal();
        t_order_positive();
        t_order_negative();
        t_zeros();
        t_denormals();
        t_nan_quiet();
        t_nan_signal();
        t_precision_select();
        t_hold();
        t_reset_again();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule